// File: doc/BRIEF.md
# Conversion Result Window Watchdog

This block checks each finished conversion result against a programmable window made of a low bound and a high bound. When a result that the block is set to guard lies outside the window, it sets a sticky event flag. The flag also drives an interrupt line when the interrupt enable is set. Software clears the flag with a one-cycle clear strobe.

With each result the converter delivers a valid strobe, the raw 12-bit value (before any left or right alignment), the channel number, and a bit that marks the result as coming from the regular group or the injected group. Guarding is selected in two ways. A single-channel select limits checking to one programmed channel, or leaves it off so that every channel is checked. Two independent group enables admit regular results, injected results, or both. These settings give seven modes: single regular, single injected, single regular-or-injected, all regular, all injected, all regular and injected, and none.

Top module: `awd_window_guard`

## Requirements
- R1: While reset is asserted, and at the first sampling point after its release, `awd_flag` and `awd_irq` are 0.
- R2: A guarded result whose value is strictly greater than `cfg_thr_hi` sets `awd_flag` at the rising clock edge that samples `res_valid`.
- R3: A guarded result whose value is strictly less than `cfg_thr_lo` sets `awd_flag` at the same edge.
- R4: A guarded result with `cfg_thr_lo <= value <= cfg_thr_hi` does not set the flag. A value equal to either bound counts as inside.
- R5: With `cfg_single` = 1, only results whose `res_chan` equals `cfg_guard_chan` are guarded. With `cfg_single` = 0, a result on any channel is guarded.
- R6: `res_is_inj` = 0 marks a regular result, which is guarded only when `cfg_reg_en` = 1. `res_is_inj` = 1 marks an injected result, which is guarded only when `cfg_inj_en` = 1. With both enables at 0, no result sets the flag.
- R7: While `res_valid` is 0, the data, channel and group inputs have no effect on the flag.
- R8: Once set, `awd_flag` stays at 1 until a cycle with `flag_clr` = 1 and no new event. That cycle clears it at the next edge.
- R9: When an event and `flag_clr` fall in the same cycle, the event wins and the flag is 1 after the edge.
- R10: `awd_irq` is 1 exactly when `awd_flag` = 1 and `cfg_irq_en` = 1, with no extra cycle of delay. `cfg_irq_en` never changes the flag.
- R11: When `cfg_thr_lo` > `cfg_thr_hi`, every guarded result is outside the window and sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_thr_hi | input | DATA_W | Upper window bound, inclusive |
| cfg_thr_lo | input | DATA_W | Lower window bound, inclusive |
| cfg_single | input | 1 | 1: guard one channel only; 0: guard all channels |
| cfg_guard_chan | input | CH_W | Channel guarded when cfg_single = 1 |
| cfg_reg_en | input | 1 | Guard regular-group results |
| cfg_inj_en | input | 1 | Guard injected-group results |
| cfg_irq_en | input | 1 | Route the flag to the interrupt output |
| res_valid | input | 1 | One-cycle strobe for a finished conversion |
| res_data | input | DATA_W | Raw conversion value |
| res_chan | input | CH_W | Channel of the result |
| res_is_inj | input | 1 | 1: injected-group result; 0: regular-group result |
| flag_clr | input | 1 | Software clear of the event flag |
| awd_flag | output | 1 | Sticky out-of-window flag |
| awd_irq | output | 1 | Interrupt request |

## Verification
The software clear and a new out-of-window event can arrive in the same cycle, and the rule that the event wins is the one most likely to be broken. The bench first sets the flag. It then raises `flag_clr` in the same cycle as an outside result on a guarded channel, and checks that the flag still reads 1 after the edge. A second case pairs the clear with an in-window result, and the flag must then drop. This shows that the clear itself works and that only a real event overrides it.

// File: rtl/awd_pkg.sv
package awd_pkg;

  // Result origin as carried by the group bit
  typedef enum logic {
    GRP_REGULAR  = 1'b0,
    GRP_INJECTED = 1'b1
  } awd_grp_e;

  // Outcome of the window comparison
  typedef struct packed {
    logic above_hi;
    logic below_lo;
  } awd_cmp_t;

endpackage

// File: rtl/awd_guard_sel.sv
module awd_guard_sel
  import awd_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            res_valid,
  input  logic [CH_W-1:0] res_chan,
  input  logic            res_is_inj,
  input  logic            cfg_single,
  input  logic [CH_W-1:0] cfg_guard_chan,
  input  logic            cfg_reg_en,
  input  logic            cfg_inj_en,
  output logic            guarded
);

  logic     chan_ok;
  logic     grp_ok;
  awd_grp_e grp;

  always_comb begin
    grp     = awd_grp_e'(res_is_inj);
    chan_ok = !cfg_single || (res_chan == cfg_guard_chan);
    grp_ok  = (grp == GRP_INJECTED) ? cfg_inj_en : cfg_reg_en;
    guarded = res_valid && chan_ok && grp_ok;
  end

endmodule

// File: rtl/awd_window_cmp.sv
module awd_window_cmp
  import awd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] bound_hi,
  input  logic [DATA_W-1:0] bound_lo,
  output awd_cmp_t          cmp,
  output logic              outside
);

  always_comb begin
    cmp.above_hi = (value > bound_hi);
    cmp.below_lo = (value < bound_lo);
    outside      = cmp.above_hi || cmp.below_lo;
  end

endmodule

// File: rtl/awd_sticky_flag.sv
module awd_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  // next state: a set overrides a simultaneous clear
  always_comb begin
    flag_en = set_evt || clr_req;
    flag_d  = set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/awd_window_guard.sv
module awd_window_guard
  import awd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cfg_thr_hi,
  input  logic [DATA_W-1:0] cfg_thr_lo,
  input  logic              cfg_single,
  input  logic [CH_W-1:0]   cfg_guard_chan,
  input  logic              cfg_reg_en,
  input  logic              cfg_inj_en,
  input  logic              cfg_irq_en,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [CH_W-1:0]   res_chan,
  input  logic              res_is_inj,
  input  logic              flag_clr,
  output logic              awd_flag,
  output logic              awd_irq
);

  logic     guarded;
  logic     outside;
  awd_cmp_t cmp_res;
  logic     guard_hit;
  logic     flag_int;

  awd_guard_sel #(.CH_W(CH_W)) u_sel (
    .res_valid      (res_valid),
    .res_chan       (res_chan),
    .res_is_inj     (res_is_inj),
    .cfg_single     (cfg_single),
    .cfg_guard_chan (cfg_guard_chan),
    .cfg_reg_en     (cfg_reg_en),
    .cfg_inj_en     (cfg_inj_en),
    .guarded        (guarded)
  );

  awd_window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .value    (res_data),
    .bound_hi (cfg_thr_hi),
    .bound_lo (cfg_thr_lo),
    .cmp      (cmp_res),
    .outside  (outside)
  );

  assign guard_hit = guarded && outside;

  awd_sticky_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (guard_hit),
    .clr_req (flag_clr),
    .flag    (flag_int)
  );

  assign awd_flag = flag_int;
  assign awd_irq  = flag_int && cfg_irq_en;

endmodule

// File: rtl/awd_window_guard_chk.sv
module awd_window_guard_chk #(
  parameter int DATA_W = 12,
  parameter int CH_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] cfg_thr_hi,
  input logic [DATA_W-1:0] cfg_thr_lo,
  input logic              cfg_single,
  input logic [CH_W-1:0]   cfg_guard_chan,
  input logic              cfg_reg_en,
  input logic              cfg_inj_en,
  input logic              cfg_irq_en,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic [CH_W-1:0]   res_chan,
  input logic              res_is_inj,
  input logic              flag_clr,
  input logic              awd_flag,
  input logic              awd_irq,
  input logic              guard_hit
);

  logic port_guarded;
  assign port_guarded = res_valid
                     && (!cfg_single || res_chan == cfg_guard_chan)
                     && (res_is_inj ? cfg_inj_en : cfg_reg_en);

  // R2
  above_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_guarded && res_data > cfg_thr_hi) |=> awd_flag);

  // R3
  below_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_guarded && res_data < cfg_thr_lo) |=> awd_flag);

  // R4
  inside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!awd_flag && port_guarded && res_data >= cfg_thr_lo && res_data <= cfg_thr_hi)
      |=> !awd_flag);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!awd_flag && !res_valid) |=> !awd_flag);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awd_flag && !flag_clr) |=> awd_flag);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_hit && flag_clr) |=> awd_flag);

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !awd_flag |-> !awd_irq);

  // R10
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |-> !awd_irq);

endmodule

bind awd_window_guard awd_window_guard_chk #(.DATA_W(DATA_W), .CH_W(CH_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_thr_hi     (cfg_thr_hi),
  .cfg_thr_lo     (cfg_thr_lo),
  .cfg_single     (cfg_single),
  .cfg_guard_chan (cfg_guard_chan),
  .cfg_reg_en     (cfg_reg_en),
  .cfg_inj_en     (cfg_inj_en),
  .cfg_irq_en     (cfg_irq_en),
  .res_valid      (res_valid),
  .res_data       (res_data),
  .res_chan       (res_chan),
  .res_is_inj     (res_is_inj),
  .flag_clr       (flag_clr),
  .awd_flag       (awd_flag),
  .awd_irq        (awd_irq),
  .guard_hit      (guard_hit)
);

// File: tb/tb_awd_window_guard.sv
module tb_awd_window_guard;

  localparam int DW = 12;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] cfg_thr_hi, cfg_thr_lo;
  logic          cfg_single, cfg_reg_en, cfg_inj_en, cfg_irq_en;
  logic [CW-1:0] cfg_guard_chan;
  logic          res_valid, res_is_inj, flag_clr;
  logic [DW-1:0] res_data;
  logic [CW-1:0] res_chan;
  logic          awd_flag, awd_irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  awd_window_guard #(.DATA_W(DW), .CH_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_thr_hi(cfg_thr_hi), .cfg_thr_lo(cfg_thr_lo),
    .cfg_single(cfg_single), .cfg_guard_chan(cfg_guard_chan),
    .cfg_reg_en(cfg_reg_en), .cfg_inj_en(cfg_inj_en), .cfg_irq_en(cfg_irq_en),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
    .res_is_inj(res_is_inj), .flag_clr(flag_clr),
    .awd_flag(awd_flag), .awd_irq(awd_irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic expect_hit(input logic [DW-1:0] d, input logic [CW-1:0] ch,
                                      input logic inj, input logic vld);
    logic g;
    g = vld && (!cfg_single || ch == cfg_guard_chan) && (inj ? cfg_inj_en : cfg_reg_en);
    return g && ((d > cfg_thr_hi) || (d < cfg_thr_lo));
  endfunction

  // clear flag, present one result, check flag after the capturing edge
  task automatic trial(input string req, input logic [DW-1:0] d, input logic [CW-1:0] ch,
                       input logic inj, input logic vld);
    logic e;
    @(negedge clk); flag_clr = 1'b1; res_valid = 1'b0;
    @(negedge clk); flag_clr = 1'b0;
    res_valid = vld; res_data = d; res_chan = ch; res_is_inj = inj;
    e = expect_hit(d, ch, inj, vld);
    @(negedge clk); res_valid = 1'b0;
    chk(req, awd_flag, e);
    chk({req, " R10"}, awd_irq, e && cfg_irq_en);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] pts [8];
    rst_n = 1'b0; flag_clr = 1'b0; res_valid = 1'b0; res_data = '0; res_chan = '0;
    res_is_inj = 1'b0; cfg_thr_hi = 12'd3000; cfg_thr_lo = 12'd1000; cfg_single = 1'b0;
    cfg_guard_chan = 5'd7; cfg_reg_en = 1'b1; cfg_inj_en = 1'b1; cfg_irq_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 flag in reset", awd_flag, 1'b0);
    chk("R1 irq in reset", awd_irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flag after release", awd_flag, 1'b0);

    // R2 R3 R4: full value sweep, all channels, both groups
    for (int v = 0; v < 4096; v++)
      trial(v > 3000 ? "R2 sweep" : (v < 1000 ? "R3 sweep" : "R4 sweep"),
            DW'(v), CW'(v % 32), v[0], 1'b1);

    // R5 R6: all guard modes, both groups, matching and other channel
    pts = '{12'd0, 12'd999, 12'd1000, 12'd1001, 12'd2999, 12'd3000, 12'd3001, 12'd4095};
    for (int m = 0; m < 8; m++) begin
      cfg_single = m[2]; cfg_reg_en = m[1]; cfg_inj_en = m[0];
      for (int g = 0; g < 2; g++)
        for (int c = 0; c < 2; c++)
          for (int p = 0; p < 8; p++)
            trial(c == 0 ? "R6 group mode" : "R5 channel mode", pts[p],
                  c == 0 ? 5'd7 : 5'd12, g[0], 1'b1);
    end

    // R7: invalid strobes never set the flag
    cfg_single = 1'b0; cfg_reg_en = 1'b1; cfg_inj_en = 1'b1;
    for (int p = 0; p < 8; p++) trial("R7 no valid", pts[p], 5'd3, p[0], 1'b0);

    // R8: sticky through idle cycles, then clear
    trial("R8 set", 12'd4000, 5'd1, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    chk("R8 held", awd_flag, 1'b1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R8 cleared", awd_flag, 1'b0);

    // R9: clear and event same cycle; then clear with inside result
    trial("R9 pre", 12'd10, 5'd1, 1'b1, 1'b1);
    @(negedge clk); flag_clr = 1'b1; res_valid = 1'b1; res_data = 12'd4000; res_chan = 5'd2;
    @(negedge clk); flag_clr = 1'b0; res_valid = 1'b0;
    chk("R9 event wins", awd_flag, 1'b1);
    @(negedge clk); flag_clr = 1'b1; res_valid = 1'b1; res_data = 12'd2000;
    @(negedge clk); flag_clr = 1'b0; res_valid = 1'b0;
    chk("R9 inside does not block clear", awd_flag, 1'b0);

    // R10: irq enable gates output only
    trial("R10 set", 12'd3500, 5'd0, 1'b0, 1'b1);
    cfg_irq_en = 1'b0; #1;
    chk("R10 irq off", awd_irq, 1'b0);
    @(negedge clk);
    chk("R10 flag unaffected", awd_flag, 1'b1);
    cfg_irq_en = 1'b1; #1;
    chk("R10 irq back", awd_irq, 1'b1);

    // R11: inverted bounds
    cfg_thr_lo = 12'd3000; cfg_thr_hi = 12'd1000;
    for (int p = 0; p < 8; p++) trial("R11 inverted", pts[p], 5'd5, p[0], 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule